// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits on the root-port side of advanced error reporting. Each cycle it can take one incoming error message. The message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester identifier. The identifier holds the bus number in its upper byte and the device/function number in its lower byte. The block records which severities have arrived and whether a second error of the same class followed the first. For a fatal error, it records whether that error was the first uncorrectable error. For each class, it keeps the identifier of the first requester.

Software sees three enable bits in a command register. It clears status bits by writing ones to them through a small write port. The block raises an interrupt when a received-status bit and its matching enable are both set. In level mode, with both message schemes off, it drives a wired interrupt line that follows this condition. In message mode it sends a one-cycle pulse, together with a vector number and a flag for the extended scheme. The pulse is sent only when the condition turns from false to true. That change can come from a new message or from a command-register write.

Top module: `rp_err_collector`

## Requirements
- R1: `msg_sev` code 0 is correctable and sets status bit 0. Code 1 is non-fatal and sets bits 2 and 5. Code 2 is fatal and sets bits 2 and 6. Code 3 is ignored and changes no register.
- R2: A correctable message that arrives while bit 0 is already set sets bit 1 and leaves `src[15:0]` unchanged. Otherwise the message stores its identifier in `src[15:0]`.
- R3: A non-fatal or fatal message that arrives while bit 2 is already set sets bit 3 and leaves `src[31:16]` unchanged. Otherwise the message stores its identifier in `src[31:16]`.
- R4: A fatal message sets bit 4 only if bit 2 was clear before that message.
- R5: When `wr_sel`=1, a write clears every status bit in [6:0] that has a 1 in `wr_data`. When `wr_sel`=0, a write loads `cmd` from `wr_data[2:0]`: bit 0 enables correctable, bit 1 enables non-fatal, bit 2 enables fatal. `status[31:27]` always shows `irq_num`, and writes cannot change it.
- R6: With `msi_en`=0 and `msix_en`=0, `intx` equals (bit0 & cmd[0]) | (bit5 & cmd[1]) | (bit6 & cmd[2]) of the current registers. The line falls when the status is cleared.
- R7: In message mode, an accepted message gives a one-cycle `msg_irq` only if the enable for its severity is set and the condition was false before the message.
- R8: In message mode, a command write gives one `msg_irq` only if the condition was false under the old command and is true under the new one.
- R9: `msg_vec` carries `irq_num`, and `msg_is_msix` is 1 when `msix_en` is set, so the extended scheme wins over MSI. `intx` stays 0 while either scheme is enabled.
- R10: Reset clears status, command and both source fields, and deasserts `intx` and `msg_irq`. Register updates appear on the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msg_valid | input | 1 | Error message strobe |
| msg_sev | input | 2 | Severity code |
| msg_src | input | SRC_W | Requester identifier |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = command, 1 = status clear |
| wr_data | input | DATA_W | Write data |
| msi_en | input | 1 | MSI scheme enabled |
| msix_en | input | 1 | MSI-X scheme enabled |
| irq_num | input | VEC_W | Interrupt message number |
| cmd | output | 3 | Enable register |
| status | output | DATA_W | Root error status |
| src | output | DATA_W | Captured identifiers |
| intx | output | 1 | Level interrupt |
| msg_irq | output | 1 | One-cycle message interrupt |
| msg_vec | output | VEC_W | Vector for the message |
| msg_is_msix | output | 1 | Message uses the extended scheme |

## Verification
The bench builds the block with its default parameters: 16-bit identifiers, a 5-bit vector and 32-bit registers. With these values both source fields fill the whole source word, and the vector field occupies the top five status bits. The check that writes cannot change the vector field can therefore compare it directly against `irq_num`. The bench also changes `irq_num` between pulses, so each queued pulse carries its own vector to compare.

// File: rtl/rp_err_collector.sv
module rp_err_collector #(
  parameter int SRC_W  = 16,
  parameter int VEC_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [1:0]        msg_sev,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              msi_en,
  input  logic              msix_en,
  input  logic [VEC_W-1:0]  irq_num,
  output logic [2:0]        cmd,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] src,
  output logic              intx,
  output logic              msg_irq,
  output logic [VEC_W-1:0]  msg_vec,
  output logic              msg_is_msix
);
  localparam int ST_W = 7;
  localparam int B_COR = 0, B_MCOR = 1, B_UNC = 2, B_MUNC = 3, B_FF = 4, B_NF = 5, B_FAT = 6;
  localparam logic [1:0] SEV_COR = 2'd0, SEV_NF = 2'd1, SEV_FAT = 2'd2;

  logic [ST_W-1:0]  st_q, st_clr, st_n;
  logic [2:0]       cmd_q, cmd_n;
  logic [SRC_W-1:0] csrc_q, csrc_n, usrc_q, usrc_n;
  logic             msg_mode, cond_old, cond_new;

  function automatic logic hit(input logic [ST_W-1:0] s, input logic [2:0] e);
    return (s[B_COR] & e[0]) | (s[B_NF] & e[1]) | (s[B_FAT] & e[2]);
  endfunction

  assign st_clr = (wr_en && wr_sel) ? (st_q & ~wr_data[ST_W-1:0]) : st_q;
  assign cmd_n  = (wr_en && !wr_sel) ? wr_data[2:0] : cmd_q;

  always_comb begin
    st_n   = st_clr;
    csrc_n = csrc_q;
    usrc_n = usrc_q;
    if (msg_valid) begin
      if (msg_sev == SEV_COR) begin
        if (st_clr[B_COR]) st_n[B_MCOR] = 1'b1;
        else               csrc_n = msg_src;
        st_n[B_COR] = 1'b1;
      end else if (msg_sev == SEV_NF || msg_sev == SEV_FAT) begin
        if (msg_sev == SEV_FAT) begin
          if (!st_clr[B_UNC]) st_n[B_FF] = 1'b1;
          st_n[B_FAT] = 1'b1;
        end else begin
          st_n[B_NF] = 1'b1;
        end
        if (st_clr[B_UNC]) st_n[B_MUNC] = 1'b1;
        else               usrc_n = msg_src;
        st_n[B_UNC] = 1'b1;
      end
    end
  end

  assign msg_mode = msi_en | msix_en;
  assign cond_old = hit(st_q, cmd_q);
  assign cond_new = hit(st_n, cmd_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= '0;
      cmd_q       <= '0;
      csrc_q      <= '0;
      usrc_q      <= '0;
      msg_irq     <= 1'b0;
      msg_vec     <= '0;
      msg_is_msix <= 1'b0;
    end else begin
      st_q    <= st_n;
      cmd_q   <= cmd_n;
      csrc_q  <= csrc_n;
      usrc_q  <= usrc_n;
      msg_irq <= msg_mode & ~cond_old & cond_new;
      if (msg_mode & ~cond_old & cond_new) begin
        msg_vec     <= irq_num;
        msg_is_msix <= msix_en;
      end
    end
  end

  assign cmd    = cmd_q;
  assign intx   = ~msg_mode & cond_old;
  assign status = (DATA_W'(irq_num) << (DATA_W - VEC_W)) | DATA_W'(st_q);
  assign src    = DATA_W'({usrc_q, csrc_q});
endmodule

// File: rtl/rp_err_collector_chk.sv
module rp_err_collector_chk #(
  parameter int SRC_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic [1:0]        msg_sev,
  input logic              wr_en,
  input logic              wr_sel,
  input logic              msi_en,
  input logic              msix_en,
  input logic [2:0]        cmd,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] src,
  input logic              intx,
  input logic              msg_irq
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msg_irq |=> !msg_irq);

  a_r9_pulse_in_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    msg_irq |-> $past(msi_en || msix_en));

  a_r9_intx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en || msix_en) |-> !intx);

  a_r4_first_fatal_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> (status[6] && $past(msg_valid && msg_sev == 2'd2)));

  a_r2_cor_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[0]) && !$past(wr_en && wr_sel)) |-> $stable(src[SRC_W-1:0]));

  a_r3_unc_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[2]) && !$past(wr_en && wr_sel)) |-> $stable(src[2*SRC_W-1:SRC_W]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(msg_valid) && !$past(wr_en)) |-> ($stable(status[6:0]) && $stable(cmd)));
endmodule

bind rp_err_collector rp_err_collector_chk #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
  .wr_en(wr_en), .wr_sel(wr_sel), .msi_en(msi_en), .msix_en(msix_en),
  .cmd(cmd), .status(status), .src(src), .intx(intx), .msg_irq(msg_irq)
);

// File: tb/sim_rp_err_collector.sv
`timescale 1ns/1ps
module sim_rp_err_collector;
  localparam int SRC_W = 16, VEC_W = 5, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, msi_en = 1'b0, msix_en = 1'b0;
  logic [1:0] msg_sev = '0;
  logic [SRC_W-1:0] msg_src = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [VEC_W-1:0] irq_num = 5'h13;
  logic [2:0] cmd;
  logic [DATA_W-1:0] status, src;
  logic intx, msg_irq, msg_is_msix;
  logic [VEC_W-1:0] msg_vec;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [VEC_W:0] expq[$];

  always #5 clk = ~clk;

  rp_err_collector #(.SRC_W(SRC_W), .VEC_W(VEC_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .msi_en(msi_en), .msix_en(msix_en),
    .irq_num(irq_num), .cmd(cmd), .status(status), .src(src), .intx(intx),
    .msg_irq(msg_irq), .msg_vec(msg_vec), .msg_is_msix(msg_is_msix));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sev, input logic [15:0] id);
    @(negedge clk); msg_valid = 1'b1; msg_sev = sev; msg_src = id;
    @(negedge clk); msg_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic expect_pulse();
    expq.push_back({msix_en, irq_num});
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_irq) begin
      n_run++;
      if (expq.size() == 0) begin
        n_fail++;
        $display("FAIL R7/R8: actual unexpected pulse vec %h expected none", msg_vec);
      end else begin
        logic [VEC_W:0] e;
        e = expq.pop_front();
        if ({msg_is_msix, msg_vec} !== e) begin
          n_fail++;
          $display("FAIL R9: actual %h expected %h", {msg_is_msix, msg_vec}, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 status", status[6:0], 7'h00);
    chk("R10 src", src, 32'h0);
    chk("R10 intx", {31'b0, intx}, 32'h0);
    rst_n = 1'b1;
    wr(1'b0, 32'h7);
    chk("R5 cmd load", cmd, 3'h7);
    send(2'd0, 16'h0108);
    chk("R1 cor status", status[6:0], 7'h01);
    chk("R2 cor src", src[15:0], 16'h0108);
    chk("R6 intx high", intx, 1'b1);
    send(2'd0, 16'h0210);
    chk("R2 multi cor", status[6:0], 7'h03);
    chk("R2 cor src kept", src[15:0], 16'h0108);
    wr(1'b1, 32'h3);
    chk("R5 w1c", status[6:0], 7'h00);
    chk("R6 intx falls", intx, 1'b0);
    send(2'd1, 16'h0300);
    chk("R1 nonfatal", status[6:0], 7'h24);
    chk("R3 unc src", src[31:16], 16'h0300);
    send(2'd2, 16'h0400);
    chk("R3 R4 multi unc no first fatal", status[6:0], 7'h6C);
    chk("R3 unc src kept", src[31:16], 16'h0300);
    wr(1'b1, 32'hFFFF_FFFF);
    chk("R5 clear all", status[6:0], 7'h00);
    chk("R5 vector field", status[31:27], 5'h13);
    send(2'd2, 16'h0501);
    chk("R4 first fatal", status[6:0], 7'h54);
    chk("R3 fatal src", src[31:16], 16'h0501);
    send(2'd3, 16'h0777);
    chk("R1 code 3 ignored", status[6:0], 7'h54);
    chk("R1 code 3 src", src, 32'h0501_0108);
    wr(1'b0, 32'h3);
    chk("R6 fatal masked", intx, 1'b0);
    wr(1'b0, 32'h4);
    chk("R6 fatal enabled", intx, 1'b1);

    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, 32'h0);
    @(negedge clk); msi_en = 1'b1;
    send(2'd0, 16'h0900);
    chk("R7 disabled severity", status[6:0], 7'h01);
    irq_num = 5'h07;
    expect_pulse();
    wr(1'b0, 32'h1);
    wr(1'b0, 32'h3);
    send(2'd1, 16'h0A00);
    chk("R9 intx quiet", intx, 1'b0);
    wr(1'b1, 32'hFFFF_FFFF);
    send(2'd2, 16'h0B00);
    expect_pulse();
    send(2'd1, 16'h0C00);
    @(negedge clk); msix_en = 1'b1; irq_num = 5'h1A;
    wr(1'b1, 32'hFFFF_FFFF);
    expect_pulse();
    send(2'd0, 16'h0D00);
    repeat (2) @(negedge clk);
    chk("R7 R8 queue drained", expq.size(), 0);
    msix_en = 1'b0; msi_en = 1'b0;
    @(negedge clk);
    chk("R6 back to level", intx, 1'b1);
    wr(1'b1, 32'hFFFF_FFFF);
    chk("R6 clear lowers", intx, 1'b0);
    send(2'd0, 16'h0E00);
    chk("R6 fresh error", intx, 1'b1);
    chk("R2 fresh src", src[15:0], 16'h0E00);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule